// File: doc/BRIEF.md
# DMA halt flag register with read-then-clear

This block is the halt-control slice of a DMA controller's global control register. It keeps two sticky halt flags, one for an address error detected by the transfer logic and one for a non-maskable interrupt, plus a master enable bit. From these and a per-channel enable vector it produces a registered per-channel transfer permit. It also produces a stop request that holds the current transfer unit alive until it finishes after a non-maskable interrupt.

Software reaches the slice through a one-cycle read/write port. A flag cannot be cleared by a blind write. The clearing write must write 0 to the flag's bit, and a read must have returned that flag as 1 since the last write. Only the hardware events can set a flag. If a set and a clear arrive in the same cycle, the set wins.

Register layout, which software decodes: bit 0 is the master enable (read/write), bit 1 is the NMI flag, and bit 2 is the address-error flag. All higher bits read as 0.

Top module: `dma_halt_ctl`

## Requirements
- R1: After reset both flags, the master enable, every permit bit, the stop request and the read data are 0.
- R2: An address-error pulse sets the address-error flag (bit 2) at the next clock edge. An NMI pulse sets the NMI flag (bit 1) at the next edge, whether or not a transfer unit is busy.
- R3: Writing 1 to bit 1 or bit 2 never sets a flag.
- R4: A flag clears only through a write with 0 in its bit, and only when a read since the last write returned that flag as 1. A write of 0 without such a read leaves the flag set.
- R5: Any write disarms both flags. After a read, a write with 1 in the flag's bit leaves the flag set, and a following write of 0 without a new read also leaves it set.
- R6: When a set event and a valid clearing write fall in the same cycle, the flag stays 1.
- R7: With no flag set, each permit bit is registered: `permit[i]` equals master enable AND `chan_en[i]` as of the previous edge.
- R8: An address-error pulse forces every permit bit to 0 at the next edge. While the address-error flag is 1, the permit stays 0.
- R9: An NMI pulse while `unit_busy` is 1 and `unit_done` is 0 raises `stop_req` at the next edge. The permit is kept until the edge after `unit_done`, and at that edge both the permit and `stop_req` fall.
- R10: An NMI pulse while no unit is busy, or in the same cycle as `unit_done`, forces every permit bit to 0 at the next edge with no stop request.
- R11: Read data is combinational: bit 0 is the master enable, bit 1 the NMI flag, bit 2 the address-error flag, and bits 3 and up are 0.
- R12: Any write loads bit 0 of the write data into the master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_err_evt | input | 1 | Address-error event pulse |
| nmi_evt | input | 1 | NMI event pulse |
| chan_en | input | NCH | Per-channel enable |
| unit_busy | input | 1 | A transfer unit is in progress |
| unit_done | input | 1 | The current transfer unit completes this cycle |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data |
| flag_ae | output | 1 | Address-error flag |
| flag_nmi | output | 1 | NMI flag |
| permit | output | NCH | Registered per-channel transfer permit |
| stop_req | output | 1 | Stop pending until the current unit ends |

## Verification
The bench builds the block with NCH=4 and REG_W=8. With four channels, every combination of master enable and channel enables (32 cases) can be swept and compared against an arithmetic AND. For each flag, the bench also sweeps every pairing of read-before-write with a written bit value, which covers all paths through the read-then-clear rule. Further cases cover same-cycle set against clear, an NMI inside and outside a busy unit, and an NMI that coincides with the unit's last cycle.

// File: rtl/dma_halt_ctl.sv
module dma_halt_ctl #(
  parameter int NCH   = 4,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_err_evt,
  input  logic             nmi_evt,
  input  logic [NCH-1:0]   chan_en,
  input  logic             unit_busy,
  input  logic             unit_done,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             flag_ae,
  output logic             flag_nmi,
  output logic [NCH-1:0]   permit,
  output logic             stop_req
);
  localparam int ME_BIT  = 0;
  localparam int NMI_BIT = 1;
  localparam int AE_BIT  = 2;

  logic me_q, ae_q, nmi_q, arm_ae, arm_nmi, stop_q;
  logic ae_n, nmi_n, stop_n, clr_ae, clr_nmi, go;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata[REG_W-1:AE_BIT+1];

  assign clr_ae  = reg_wr && !reg_wdata[AE_BIT]  && arm_ae;
  assign clr_nmi = reg_wr && !reg_wdata[NMI_BIT] && arm_nmi;
  assign ae_n    = addr_err_evt || (ae_q  && !clr_ae);
  assign nmi_n   = nmi_evt      || (nmi_q && !clr_nmi);
  assign stop_n  = !unit_done && ((nmi_evt && unit_busy) || stop_q);
  assign go      = (reg_wr ? reg_wdata[ME_BIT] : me_q) && !ae_n && !(nmi_n && !stop_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      me_q    <= 1'b0;
      ae_q    <= 1'b0;
      nmi_q   <= 1'b0;
      arm_ae  <= 1'b0;
      arm_nmi <= 1'b0;
      stop_q  <= 1'b0;
      permit  <= '0;
    end else begin
      if (reg_wr) me_q <= reg_wdata[ME_BIT];
      ae_q    <= ae_n;
      nmi_q   <= nmi_n;
      arm_ae  <= (reg_rd && ae_q)  || (arm_ae  && !reg_wr);
      arm_nmi <= (reg_rd && nmi_q) || (arm_nmi && !reg_wr);
      stop_q  <= stop_n;
      permit  <= go ? chan_en : '0;
    end
  end

  always_comb begin
    reg_rdata          = '0;
    reg_rdata[ME_BIT]  = me_q;
    reg_rdata[NMI_BIT] = nmi_q;
    reg_rdata[AE_BIT]  = ae_q;
  end

  assign flag_ae  = ae_q;
  assign flag_nmi = nmi_q;
  assign stop_req = stop_q;

  p_set_ae_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_evt |=> flag_ae);
  p_set_nmi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_evt |=> flag_nmi);
  p_no_write_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ae) |-> $past(addr_err_evt));
  p_clear_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_nmi) |-> $past(reg_wr && !reg_wdata[NMI_BIT] && arm_nmi));
  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd) |=> !arm_ae && !arm_nmi);
  p_ae_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ae |-> permit == '0);
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !unit_done) |=> stop_req);
  p_stop_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> !stop_req);
  p_nmi_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_nmi && !stop_req) |-> permit == '0);
  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:AE_BIT+1] == '0);
endmodule

// File: tb/test_dma_halt_ctl.sv
module test_dma_halt_ctl;
  localparam int NCH = 4;
  localparam int REG_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_err_evt = 0, nmi_evt = 0, unit_busy = 0, unit_done = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [NCH-1:0] chan_en = '0;
  logic [REG_W-1:0] reg_rdata;
  logic flag_ae, flag_nmi, stop_req;
  logic [NCH-1:0] permit;

  int errors = 0, checks = 0;
  bit finished = 0;

  dma_halt_ctl #(.NCH(NCH), .REG_W(REG_W)) i_dma_halt_ctl (
    .clk, .rst_n, .addr_err_evt, .nmi_evt, .chan_en, .unit_busy, .unit_done,
    .reg_rd, .reg_wr, .reg_wdata, .reg_rdata, .flag_ae, .flag_nmi,
    .permit, .stop_req);

  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(output logic [REG_W-1:0] d);
    reg_rd = 1; #1; d = reg_rdata; step(); reg_rd = 0;
  endtask

  task automatic wr(input logic [REG_W-1:0] v);
    reg_wr = 1; reg_wdata = v; step(); reg_wr = 0;
  endtask

  task automatic pulse(input bit ae);
    if (ae) addr_err_evt = 1; else nmi_evt = 1;
    step(); addr_err_evt = 0; nmi_evt = 0;
  endtask

  task automatic clear_all();
    logic [REG_W-1:0] d;
    rd(d); wr(8'h01); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [REG_W-1:0] d;
    step(); step(); rst_n = 1; step();
    // R1 reset state
    check("R1 flags", {flag_ae, flag_nmi, stop_req}, 0);
    check("R1 permit", permit, 0);
    check("R1 rdata", reg_rdata, 0);

    // R12, R3, R11: write all ones, only ME sticks
    wr(8'hFF); #0;
    check("R3/R12 rdata", reg_rdata, 8'h01);
    rd(d);
    check("R11 read", d, 8'h01);

    // R7 sweep over ME and channel enables
    for (int me = 0; me < 2; me++)
      for (int ch = 0; ch < (1 << NCH); ch++) begin
        chan_en = ch[NCH-1:0];
        wr(me[REG_W-1:0]);
        step();
        check("R7 permit", permit, me ? ch : 0);
      end

    wr(8'h01); chan_en = '1; step();
    check("R7 all on", permit, 4'hF);

    // R2/R10 NMI outside a unit
    pulse(0);
    check("R2 nmi set", flag_nmi, 1);
    check("R10 permit off", permit, 0);
    check("R10 no stop", stop_req, 0);
    rd(d);
    check("R11 nmi read", d, 8'h03);
    wr(8'h01); step();
    check("R4 nmi cleared", flag_nmi, 0);
    check("R7 permit back", permit, 4'hF);

    // R4/R5 sweep: per flag, read-or-not, written bit value
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 2; r++)
        for (int wv = 0; wv < 2; wv++) begin
          pulse(f == 1);
          if (r) rd(d);
          wr(8'h01 | (wv ? (f ? 8'h04 : 8'h02) : 8'h00));
          check(f ? "R4 ae clear rule" : "R4 nmi clear rule",
                f ? flag_ae : flag_nmi, (r && !wv) ? 0 : 1);
          check("R4 other flag", f ? flag_nmi : flag_ae, 0);
          if (r && wv) begin
            wr(8'h01);
            check("R5 disarmed", f ? flag_ae : flag_nmi, 1);
          end
          clear_all();
        end
    check("R4 all clear", {flag_ae, flag_nmi}, 0);

    // R6 set wins
    pulse(1); rd(d);
    addr_err_evt = 1; wr(8'h01); addr_err_evt = 0;
    check("R6 set wins", flag_ae, 1);
    clear_all();
    check("R6 then clears", flag_ae, 0);

    // R8 address error halts
    step();
    check("R8 pre permit", permit, 4'hF);
    pulse(1);
    check("R8 permit off", permit, 0);
    check("R8 no stop", stop_req, 0);
    step();
    check("R8 held", permit, 0);
    clear_all();

    // R9 NMI during a unit
    unit_busy = 1; pulse(0);
    check("R9 stop", stop_req, 1);
    check("R9 permit kept", permit, 4'hF);
    step(); step();
    check("R9 still kept", permit, 4'hF);
    unit_done = 1; step(); unit_done = 0; unit_busy = 0;
    check("R9 permit end", permit, 0);
    check("R9 stop end", stop_req, 0);
    clear_all();

    // R10 NMI coincident with done
    unit_busy = 1; unit_done = 1; nmi_evt = 1; step();
    nmi_evt = 0; unit_done = 0; unit_busy = 0;
    check("R10 done same cycle permit", permit, 0);
    check("R10 done same cycle stop", stop_req, 0);
    clear_all();
    check("R7 final", permit, 4'hF);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule